// File: doc/BRIEF.md
# Multi-Phase PWM Timer Channel

This block is one channel of a pulse-width timer. It holds a 16-bit up-counter and four compare registers, each paired with one output pin. Software picks, at run time, which of the four registers sets the period. The counter advances on each cycle in which the count-enable input is high. When it reaches the period value it wraps to zero. The other three registers act as duty thresholds. Each one moves its own pin when the counter reaches it, so a single channel yields up to three PWM phases sharing one period.

Each pin has a 4-bit control field. Bit 3 is the level the pin is reloaded to at every period wrap. Bits 1:0 are the action taken when the counter hits that pin's threshold. The pin tied to the period register produces no waveform and simply holds its reload level. On every period wrap the channel emits a one-cycle clear pulse. Another channel can feed that pulse into its external clear input so that several channels run phase-aligned.

Top module: `mpwm_channel`

## Requirements
- R1: After synchronous reset, `count_o` is 0, all pins are 0 and `clr_o` is 0. Every compare register, every control field and the period select are 0.
- R2: The counter goes up by one on each cycle with `cnt_en` high, and it holds when `cnt_en` is low. These rules apply when no wrap, external clear or period-select write takes place.
- R3: A cycle in which `cnt_en` is high and the count equals the period register is a period match. On the following edge `count_o` becomes 0 and `clr_o` is high for that one cycle, unless an external clear or a select write also occurs in that cycle.
- R4: A cycle in which `cnt_en` is high and the count equals a duty register (but not the period value) sets that pin from control bits 1:0. The codes are 00 keep, 01 drive 0, 10 drive 1 and 11 invert. The new level appears on the edge that ends the match cycle.
- R5: On a period match, every duty pin is reloaded to bit 3 of its own control field.
- R6: A duty pin whose register equals the period register keeps its level at the period match. It is neither reloaded nor acted upon.
- R7: The pin of the register chosen as period always drives bit 3 of its own control field. It changes only one edge after that field or the selection changes.
- R8: Writing the period select resets the counter to 0 and loads every pin with its reload level on the write edge.
- R9: `ext_clr` high resets the counter to 0 and loads every pin with its reload level on the next edge. It takes priority over counting and matching, and it produces no `clr_o` pulse.
- R10: The register map is as follows. Addresses 0..3 hold the compare registers (`wr_data[15:0]`). Addresses 4..7 hold the control fields of pins 0..3 (`wr_data[3:0]`). Address 8 holds the period select (`wr_data[1:0]`). A write is used by match logic from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable pulse |
| ext_clr | input | 1 | External counter clear for chaining |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| pin_o | output | 4 | PWM output pins, bit i belongs to compare register i |
| clr_o | output | 1 | One-cycle pulse on each period match |

## Verification
Every result of this channel is registered. The count, the pin levels and the clear pulse all change on the single rising edge that ends the cycle in which the enable, clear or write was presented. The one exception is the period pin after a control write, which follows one edge later because the new field is only visible once stored. The bench drives each stimulus on a falling edge and compares all outputs on the next falling edge. It checks against a requirement-level model that is advanced once per cycle. As a result, every comparison lands exactly one edge after the stimulus that caused it.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CTL_W    = 4;
  localparam int INIT_BIT = 3;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } match_act_e;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    match_act_e a;
    a = match_act_e'(code);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_INVERT: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/mpwm_regfile.sv
module mpwm_regfile
  import mpwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [NCH-1:0][CNT_W-1:0]   cmp_q,
  output logic [NCH-1:0][CTL_W-1:0]   ctl_q,
  output logic [SEL_W-1:0]            sel_q,
  output logic                        sel_wr
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(2 * NCH);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wr_data[CNT_W-1:CTL_W];

  assign sel_wr = wr_en && (wr_addr == SEL_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[i] <= '0;
        ctl_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(i))       cmp_q[i] <= wr_data;
        if (wr_addr == ADDR_W'(NCH + i)) ctl_q[i] <= wr_data[CTL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_wr) sel_q <= wr_data[SEL_W-1:0];
  end
endmodule

// File: rtl/mpwm_counter.sv
module mpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] period_val,
  output logic [CNT_W-1:0] count_q,
  output logic             period_hit,
  output logic             clr_q
);
  assign period_hit = cnt_en && (count_q == period_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= period_hit && !restart;
      if (restart || period_hit) count_q <= '0;
      else if (cnt_en)           count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/mpwm_pin.sv
module mpwm_pin
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             restart,
  input  logic             is_period,
  input  logic             period_hit,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] own_cmp,
  input  logic [CNT_W-1:0] period_val,
  input  logic             init_lvl,
  input  logic [1:0]       act,
  output logic             pin_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (is_period || restart) begin
      pin_q <= init_lvl;
    end else if (period_hit) begin
      if (own_cmp != period_val) pin_q <= init_lvl;
    end else if (cnt_en && (count == own_cmp)) begin
      pin_q <= apply_act(act, pin_q);
    end
  end
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
  import mpwm_pkg::*;
#(
  parameter int  NCH    = 4,
  parameter int  CNT_W  = 16,
  localparam int ADDR_W = $clog2(2 * NCH + 1),
  localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              ext_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic [NCH-1:0]    pin_o,
  output logic              clr_o
);
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic [NCH-1:0][CTL_W-1:0] ctl_q;
  logic [SEL_W-1:0]          sel_q;
  logic                      sel_wr;
  logic [CNT_W-1:0]          period_val;
  logic                      period_hit;
  logic                      restart;

  mpwm_regfile #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_q(cmp_q), .ctl_q(ctl_q), .sel_q(sel_q), .sel_wr(sel_wr)
  );

  assign period_val = cmp_q[sel_q];
  assign restart    = ext_clr || sel_wr;

  mpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .restart(restart),
    .period_val(period_val), .count_q(count_o),
    .period_hit(period_hit), .clr_q(clr_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    logic unused_rsvd_bit;
    assign unused_rsvd_bit = ctl_q[i][2];

    mpwm_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .restart(restart),
      .is_period(sel_q == SEL_W'(i)), .period_hit(period_hit),
      .count(count_o), .own_cmp(cmp_q[i]), .period_val(period_val),
      .init_lvl(ctl_q[i][INIT_BIT]), .act(ctl_q[i][1:0]),
      .pin_q(pin_o[i])
    );
  end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk
  import mpwm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cnt_en,
  input logic                      ext_clr,
  input logic                      sel_wr,
  input logic [CNT_W-1:0]          period_val,
  input logic [SEL_W-1:0]          sel_q,
  input logic [NCH-1:0][CTL_W-1:0] ctl_q,
  input logic [CNT_W-1:0]          count_o,
  input logic [NCH-1:0]            pin_o,
  input logic                      clr_o
);
  logic past_ok;
  logic per_init;
  logic per_pin;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign per_init = ctl_q[sel_q][INIT_BIT];
  assign per_pin  = pin_o[sel_q];

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> (count_o == '0));

  // R3
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cnt_en && !ext_clr && !sel_wr && (count_o == period_val))
    |-> (clr_o && (count_o == '0)));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(cnt_en) && !$past(ext_clr) && !$past(sel_wr) && !clr_o
    |-> (count_o == CNT_W'($past(count_o) + 1'b1)));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(cnt_en) && !$past(ext_clr) && !$past(sel_wr)
    |-> $stable(count_o));

  // R9
  ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ext_clr) |-> ((count_o == '0) && !clr_o));

  // R8
  sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(sel_wr) |-> (count_o == '0));

  // R7
  period_pin_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $stable(sel_q) && $stable(per_init) |-> (per_pin == per_init));
endmodule

bind mpwm_channel mpwm_chk #(.NCH(NCH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .ext_clr(ext_clr), .sel_wr(sel_wr),
  .period_val(period_val), .sel_q(sel_q), .ctl_q(ctl_q),
  .count_o(count_o), .pin_o(pin_o), .clr_o(clr_o)
);

// File: tb/tb_mpwm_channel.sv
module tb_mpwm_channel;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst, cnt_en, ext_clr, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  wr_data;
  logic [CNT_W-1:0]  count_o;
  logic [NCH-1:0]    pin_o;
  logic              clr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0] e_cmp [NCH];
  logic [3:0]       e_ctl [NCH];
  int               e_sel;
  logic [CNT_W-1:0] e_cnt;
  logic [NCH-1:0]   e_pin;
  logic             e_clr;

  always #(CLK_P/2) clk = ~clk;

  mpwm_channel #(.NCH(NCH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .ext_clr(ext_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .pin_o(pin_o), .clr_o(clr_o)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic cmp_val(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp_val(tag, "count", int'(count_o), int'(e_cnt));
    cmp_val(tag, "pins",  int'(pin_o),   int'(e_pin));
    cmp_val(tag, "clr",   int'(clr_o),   int'(e_clr));
  endtask

  // Requirement-level model of one clock cycle
  task automatic model_step(bit en, bit xc, bit we, int addr, logic [CNT_W-1:0] data);
    logic [NCH-1:0] np;
    bit wsel, pm;
    wsel = we && (addr == 2*NCH);
    pm   = en && (e_cnt == e_cmp[e_sel]);
    np   = e_pin;
    for (int i = 0; i < NCH; i++) begin
      if (i == e_sel || xc || wsel) np[i] = e_ctl[i][3];
      else if (pm) begin
        if (e_cmp[i] != e_cmp[e_sel]) np[i] = e_ctl[i][3];
      end else if (en && e_cnt == e_cmp[i]) begin
        case (e_ctl[i][1:0])
          2'b01: np[i] = 1'b0;
          2'b10: np[i] = 1'b1;
          2'b11: np[i] = ~e_pin[i];
          default: np[i] = e_pin[i];
        endcase
      end
    end
    e_clr = pm && !xc && !wsel;
    if (xc || wsel || pm) e_cnt = '0;
    else if (en) e_cnt = e_cnt + 1'b1;
    e_pin = np;
    if (we) begin
      if (addr < NCH) e_cmp[addr] = data;
      else if (addr < 2*NCH) e_ctl[addr-NCH] = data[3:0];
      else if (wsel) e_sel = int'(data[1:0]);
    end
  endtask

  task automatic cycle(string tag, bit en, bit xc, bit we, int addr, logic [CNT_W-1:0] data);
    cnt_en  = en;
    ext_clr = xc;
    wr_en   = we;
    wr_addr = ADDR_W'(addr);
    wr_data = data;
    @(posedge clk);
    @(negedge clk);
    model_step(en, xc, we, addr, data);
    cnt_en = 1'b0; ext_clr = 1'b0; wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic wr(string tag, int addr, logic [CNT_W-1:0] data);
    cycle(tag, 1'b0, 1'b0, 1'b1, addr, data);
  endtask

  task automatic run(string tag, int n);
    for (int k = 0; k < n; k++) cycle(tag, 1'b1, 1'b0, 1'b0, 0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1; cnt_en = 1'b0; ext_clr = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NCH; i++) begin e_cmp[i] = '0; e_ctl[i] = '0; end
    e_sel = 0; e_cnt = '0; e_pin = '0; e_clr = 1'b0;
    check_all("R1");
  endtask

  task automatic t_count();
    wr("R10", 0, 16'd100);
    for (int k = 0; k < 12; k++)
      cycle("R2", (k % 3) != 1, 1'b0, 1'b0, 0, '0);
  endtask

  task automatic t_waves();
    wr("R10", 3, 16'd9);
    wr("R10", 0, 16'd3);  wr("R10", 4, 16'h9);
    wr("R10", 1, 16'd6);  wr("R10", 5, 16'h2);
    wr("R10", 2, 16'd5);  wr("R10", 6, 16'h3);
    wr("R10", 7, 16'h0);
    wr("R8", 8, 16'd3);
    run("R3/R4/R5", 25);
  endtask

  task automatic t_equal();
    wr("R10", 1, 16'd9);  wr("R10", 5, 16'h9);
    wr("R10", 4, 16'h8);
    wr("R8", 8, 16'd3);
    run("R6", 22);
  endtask

  task automatic t_period_pin();
    wr("R7", 7, 16'h8);
    run("R7", 12);
    wr("R7", 7, 16'h0);
    run("R7", 3);
    wr("R7", 5, 16'hB);
    wr("R7", 8, 16'd1);
    run("R7", 8);
  endtask

  task automatic t_sel_write();
    wr("R8", 3, 16'd7);
    wr("R8", 8, 16'd3);
    run("R8", 5);
    wr("R8", 8, 16'd3);
    run("R8", 10);
  endtask

  task automatic t_ext_clear();
    run("R9", 4);
    cycle("R9", 1'b1, 1'b1, 1'b0, 0, '0);
    run("R9", 7);
    cycle("R9", 1'b1, 1'b1, 1'b0, 0, '0);
    cycle("R9", 1'b0, 1'b1, 1'b0, 0, '0);
    run("R9", 9);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count();
    t_waves();
    t_equal();
    t_period_pin();
    t_sel_write();
    t_ext_clear();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule